// File: doc/BRIEF.md
# Programmable Reference Clock Generator

This block derives a slower reference clock from the system clock. It divides the clock by a power of two between 1 and 128 and sets the high time to 0, 25, 50 or 75 percent of each output period. The result always goes to an internal consumer, such as a carrier modulator. The same signal can also be driven onto a shared device pin, but that pin has two other possible owners. A crystal or resonator oscillator may need the pin, or a fixed quarter-rate system clock may claim it. Either of these takes precedence over the reference clock.

Software programs the block through one 8-bit configuration word. A change of ratio or duty is held back until the current output period ends, so no shortened pulse ever appears. While the sleep input is high, the system clock is treated as stopped. Every counter then halts and every output keeps its level. A slew-limit bit is passed through unchanged to the pad.

Top module: `refclk_gen`

## Requirements
- R1: A synchronous reset (rst_ni low at a rising edge) loads the configuration word 0xC0. That value means: run bit off, pin-drive bit off, ratio code 0, duty code 2, slew-limit bit 1. After reset, ref_o, pin_o and pin_oe_o are low and slew_o is high.
- R2: Configuration word layout: bit 0 is run, bit 1 is pin-drive, bits 4:2 are the ratio code, bits 6:5 are the duty code, bit 7 is slew-limit. It is written when wr_en_i is high at a rising edge. While the run bit is 0, ref_o stays low whatever the other fields hold.
- R3: Ratio code k selects a period of 2^k source cycles (k = 0..7, i.e. divide by 1 up to 128). The first period starts at the first rising edge at which the run bit is set.
- R4: Duty code d (0..3) means d/4 high time. For ratios of 4 and above, the output is high for the first d*2^k/4 source cycles of each period. Duty code 0 keeps the output low.
- R5: At ratio 1, ref_o follows the source clock for duty codes 1 to 3, and is held low for duty code 0.
- R6: At ratio 2, duty code 2 is high for the whole first source cycle of each pair. Duty code 1 is high only in the clock-high half of that cycle. Duty code 3 adds the clock-high half of the second cycle.
- R7: A new ratio or duty code takes effect only when the current period ends. Until then, the period already running completes with its old settings.
- R8: The pin is driven (pin_oe_o high, pin_o equal to ref_o) only when both the run bit and the pin-drive bit are set and nothing of higher priority owns the pin. Otherwise pin_oe_o and pin_o are low.
- R9: While osc_xtal_i is high, pin_oe_o and pin_o are low, but ref_o keeps running.
- R10: While clkout_en_i is high and osc_xtal_i is low, pin_oe_o is high and pin_o carries the system clock divided by 4. That clock comes from a free-running count of the active edges since reset and is high when the count's bit 1 is set.
- R11: While sleep_i is high, no counter advances, writes are ignored, and ref_o and pin_o hold the level of the clock-high phase of the cycle in which sleep began. Operation resumes from the same state when sleep ends.
- R12: slew_o always equals the slew-limit bit of the configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, the source of all division |
| rst_ni | input | 1 | Synchronous active-low reset |
| sleep_i | input | 1 | Sleep: halt counters, hold outputs, ignore writes |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 8 | Configuration word to write |
| osc_xtal_i | input | 1 | Crystal/resonator oscillator mode owns the pin |
| clkout_en_i | input | 1 | Quarter-rate system clock owns the pin |
| ref_o | output | 1 | Reference clock to the internal consumer |
| pin_o | output | 1 | Shared pin data |
| pin_oe_o | output | 1 | Shared pin output enable |
| slew_o | output | 1 | Slew-limit control to the pad |

## Verification
The bench checks ref_o in both halves of every source cycle. A wrong period counter or a wrong high-time threshold therefore shows as a mismatched level within one output period, which is at most 128 cycles. A bad choice of when to reload the settings shows up within the period that follows a configuration write, as a shortened or stretched pulse. A hold register that captures the wrong state shows on the first sample after sleep is entered. Errors in pin priority or in the quarter-rate counter show at once on pin_o or pin_oe_o.

// File: rtl/refclk_pkg.sv
`timescale 1ns/1ps
// Shared widths, configuration layout and the output shaping function for
// the reference clock generator. Assumes ratios are powers of two.
package refclk_pkg;

    localparam int DIV_SEL_W = 3;                 // ratio code width
    localparam int DUTY_W    = 2;                 // duty code width (quarters)
    localparam int SPAN_W    = (1 << DIV_SEL_W);  // holds the largest ratio
    localparam int CNT_W     = SPAN_W - 1;        // position within a period
    localparam int PROD_W    = SPAN_W + DUTY_W;   // ratio times duty
    localparam int QTR_LOG2  = 2;                 // fixed quarter-rate pin clock

    localparam logic [DUTY_W-1:0] DUTY_OFF  = DUTY_W'(0);
    localparam logic [DUTY_W-1:0] DUTY_QTR  = DUTY_W'(1);
    localparam logic [DUTY_W-1:0] DUTY_HALF = DUTY_W'(2);
    localparam logic [DUTY_W-1:0] DUTY_3QTR = DUTY_W'(3);

    // Packed so that run is bit 0 and slew-limit the top bit.
    typedef struct packed {
        logic                 slew;
        logic [DUTY_W-1:0]    duty;
        logic [DIV_SEL_W-1:0] div;
        logic                 pin_en;
        logic                 run;
    } refclk_cfg_t;

    localparam int CFG_W = $bits(refclk_cfg_t);

    localparam refclk_cfg_t CFG_RESET = '{
        slew:   1'b1,
        duty:   DUTY_HALF,
        div:    '0,
        pin_en: 1'b0,
        run:    1'b0
    };

    // Turns the stored phase level into the output, mixing in the source
    // clock phase where the ratio is too short for counting alone.
    function automatic logic shape_out(
        input logic                 run,
        input logic [DIV_SEL_W-1:0] sel,
        input logic [DUTY_W-1:0]    duty,
        input logic                 lvl,
        input logic                 ck
    );
        logic res;
        if (!run || duty == DUTY_OFF) begin
            res = 1'b0;
        end else if (sel == '0) begin
            res = ck;
        end else if (sel == DIV_SEL_W'(1)) begin
            case (duty)
                DUTY_QTR:  res = lvl & ck;
                DUTY_3QTR: res = lvl | ck;
                default:   res = lvl;
            endcase
        end else begin
            res = lvl;
        end
        return res;
    endfunction

endpackage

// File: rtl/refclk_regs.sv
`timescale 1ns/1ps
// Configuration word storage. Assumes a single write strobe. Writes are
// dropped during sleep because the clock is considered stopped.
module refclk_regs
    import refclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sleep_i,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    output refclk_cfg_t      cfg_o
);

    refclk_cfg_t cfg_q;

    // Hold the configuration word; reset to defaults.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en_i && !sleep_i) begin
            cfg_q <= refclk_cfg_t'(wr_data_i);
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/refclk_divider.sv
`timescale 1ns/1ps
// Period counter and duty shaping. Ratio and duty settings are latched
// only at a period boundary. Ratios 1 and 2 mix in the source clock phase.
// During sleep, the output switches to a register that holds the level of
// the clock-high phase of the current cycle.
module refclk_divider
    import refclk_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        sleep_i,
    input  refclk_cfg_t cfg_i,
    output logic        ref_o
);

    logic                 run_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [DIV_SEL_W-1:0] sel_a_q;
    logic [DUTY_W-1:0]    duty_a_q;
    logic                 lvl_q;
    logic                 hold_q;

    logic [SPAN_W-1:0]    span_a;
    logic [CNT_W-1:0]     last_a;
    logic [CNT_W-1:0]     cnt_n;
    logic                 boundary;
    logic [DIV_SEL_W-1:0] sel_n;
    logic [DUTY_W-1:0]    duty_n;
    logic [SPAN_W-1:0]    span_n;
    logic [PROD_W-1:0]    prod_n;
    logic [PROD_W-1:0]    thr_n;
    logic                 lvl_n;
    logic                 live;

    // Next position: restart when idle or at the end of the active period.
    always_comb begin
        span_a = SPAN_W'(1) << sel_a_q;
        last_a = CNT_W'(span_a - SPAN_W'(1));
        if (!run_q || cnt_q == last_a) begin
            cnt_n = '0;
        end else begin
            cnt_n = cnt_q + CNT_W'(1);
        end
        boundary = (cnt_n == '0);
    end

    // Take new settings only when a fresh period begins.
    always_comb begin
        sel_n  = boundary ? cfg_i.div  : sel_a_q;
        duty_n = boundary ? cfg_i.duty : duty_a_q;
        span_n = SPAN_W'(1) << sel_n;
        prod_n = PROD_W'(span_n) * PROD_W'(duty_n);
        thr_n  = prod_n >> DUTY_W;
    end

    // Phase level for the next cycle, from position and high-time threshold.
    always_comb begin
        if (duty_n == DUTY_OFF) begin
            lvl_n = 1'b0;
        end else if (sel_n == '0) begin
            lvl_n = 1'b1;
        end else if (sel_n == DIV_SEL_W'(1)) begin
            lvl_n = (cnt_n == '0);
        end else begin
            lvl_n = (PROD_W'(cnt_n) < thr_n);
        end
    end

    // Advance the state on every edge outside sleep.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_q    <= 1'b0;
            cnt_q    <= '0;
            sel_a_q  <= CFG_RESET.div;
            duty_a_q <= CFG_RESET.duty;
            lvl_q    <= 1'b0;
            hold_q   <= 1'b0;
        end else if (!sleep_i) begin
            run_q    <= cfg_i.run;
            cnt_q    <= cnt_n;
            sel_a_q  <= sel_n;
            duty_a_q <= duty_n;
            lvl_q    <= lvl_n;
            hold_q   <= shape_out(cfg_i.run, sel_n, duty_n, lvl_n, 1'b1);
        end
    end

    // Live shaped output, or the held level while asleep.
    always_comb begin
        live  = shape_out(run_q, sel_a_q, duty_a_q, lvl_q, clk_i);
        ref_o = sleep_i ? hold_q : live;
    end

endmodule

// File: rtl/refclk_pinmux.sv
`timescale 1ns/1ps
// Pin ownership. Oscillator mode wins over the quarter-rate clock, which
// wins over the reference clock. The quarter-rate counter freezes in sleep.
module refclk_pinmux
    import refclk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sleep_i,
    input  logic osc_xtal_i,
    input  logic clkout_en_i,
    input  logic ref_drive_i,
    input  logic ref_i,
    output logic pin_o,
    output logic pin_oe_o
);

    logic [QTR_LOG2-1:0] qtr_q;
    logic                qtr_clk;

    // Free-running divide-by-four of the system clock.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            qtr_q <= '0;
        end else if (!sleep_i) begin
            qtr_q <= qtr_q + QTR_LOG2'(1);
        end
    end

    assign qtr_clk = qtr_q[QTR_LOG2-1];

    // Choose the pin source by fixed priority.
    always_comb begin
        if (osc_xtal_i) begin
            pin_o    = 1'b0;
            pin_oe_o = 1'b0;
        end else if (clkout_en_i) begin
            pin_o    = qtr_clk;
            pin_oe_o = 1'b1;
        end else if (ref_drive_i) begin
            pin_o    = ref_i;
            pin_oe_o = 1'b1;
        end else begin
            pin_o    = 1'b0;
            pin_oe_o = 1'b0;
        end
    end

endmodule

// File: rtl/refclk_gen.sv
`timescale 1ns/1ps
// Top of the reference clock generator: configuration, divider and pin
// arbitration. Assumes every input is synchronous to clk_i.
module refclk_gen
    import refclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sleep_i,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  logic             osc_xtal_i,
    input  logic             clkout_en_i,
    output logic             ref_o,
    output logic             pin_o,
    output logic             pin_oe_o,
    output logic             slew_o
);

    refclk_cfg_t cfg;
    logic        cfg_run;
    logic        cfg_pin;
    logic        ref_drive;

    refclk_regs u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sleep_i   (sleep_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg)
    );

    refclk_divider u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sleep_i (sleep_i),
        .cfg_i   (cfg),
        .ref_o   (ref_o)
    );

    assign cfg_run   = cfg.run;
    assign cfg_pin   = cfg.pin_en;
    assign ref_drive = cfg_run & cfg_pin;

    refclk_pinmux u_pin (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sleep_i     (sleep_i),
        .osc_xtal_i  (osc_xtal_i),
        .clkout_en_i (clkout_en_i),
        .ref_drive_i (ref_drive),
        .ref_i       (ref_o),
        .pin_o       (pin_o),
        .pin_oe_o    (pin_oe_o)
    );

    assign slew_o = cfg.slew;

endmodule

// File: rtl/refclk_gen_chk.sv
`timescale 1ns/1ps
// Property checker for refclk_gen, attached with bind. Assumes a
// synchronous active-low reset. Uses $past only once a post-reset edge exists.
module refclk_gen_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sleep_i,
    input logic osc_xtal_i,
    input logic clkout_en_i,
    input logic cfg_run,
    input logic cfg_pin,
    input logic ref_o,
    input logic pin_oe_o
);

    logic armed_q;

    // Marks that one edge out of reset has passed.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && !sleep_i && !$past(sleep_i) && !$past(cfg_run)) |-> !ref_o); // R2

    AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && sleep_i && $past(sleep_i)) |-> $stable(ref_o)); // R11

    AST_XTAL_OWNS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        osc_xtal_i |-> !pin_oe_o); // R9

    AST_QTR_OWNS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clkout_en_i && !osc_xtal_i) |-> pin_oe_o); // R10

    AST_NO_DRIVE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!osc_xtal_i && !clkout_en_i && !(cfg_run && cfg_pin)) |-> !pin_oe_o); // R8

endmodule

bind refclk_gen refclk_gen_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_i     (sleep_i),
    .osc_xtal_i  (osc_xtal_i),
    .clkout_en_i (clkout_en_i),
    .cfg_run     (cfg_run),
    .cfg_pin     (cfg_pin),
    .ref_o       (ref_o),
    .pin_oe_o    (pin_oe_o)
);

// File: tb/refclk_gen_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural model in half-cycle units, compared in both clock phases.
module refclk_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       xtal = 1'b0;
    logic       clkout = 1'b0;
    logic       ref_w, pin_w, pin_oe_w, slew_w;

    int    n_chk = 0;
    int    n_err = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Model state
    int       m_pos = 0, m_sel = 0, m_duty = 2, m_edges = 0;
    bit       m_run = 1'b0;
    bit [7:0] m_cfg = 8'hC0;

    always #10 clk = ~clk;

    refclk_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .osc_xtal_i(xtal), .clkout_en_i(clkout),
        .ref_o(ref_w), .pin_o(pin_w), .pin_oe_o(pin_oe_w), .slew_o(slew_w)
    );

    // Model update at each rising edge, using the settings from before the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_sel = 0; m_duty = 2; m_run = 1'b0;
            m_cfg = 8'hC0; m_edges = 0;
        end else if (!sleep) begin
            if (!m_run) m_pos = 0;
            else if (m_pos + 1 == (1 << m_sel)) m_pos = 0;
            else m_pos = m_pos + 1;
            if (m_pos == 0) begin
                m_sel  = int'(m_cfg[4:2]);
                m_duty = int'(m_cfg[6:5]);
            end
            m_run = m_cfg[0];
            m_edges = m_edges + 1;
            if (wr_en) m_cfg = wr_data;
        end
    end

    function automatic bit exp_ref(int half);
        int n;
        if (!m_run || m_duty == 0) return 1'b0;
        n = 1 << m_sel;
        if (n == 1) return (half == 0);
        return ((2 * m_pos + half) < (m_duty * n / 2));
    endfunction

    task automatic chk(string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare(int half);
        bit er, ep, eo;
        er = sleep ? exp_ref(0) : exp_ref(half);
        if (xtal) begin
            ep = 1'b0; eo = 1'b0;
        end else if (clkout) begin
            ep = ((m_edges >> 1) & 1) != 0; eo = 1'b1;
        end else if (m_cfg[0] && m_cfg[1]) begin
            ep = er; eo = 1'b1;
        end else begin
            ep = 1'b0; eo = 1'b0;
        end
        chk("ref_o", ref_w, er);
        chk("pin_o", pin_w, ep);
        chk("pin_oe_o", pin_oe_w, eo);
        chk("slew_o", slew_w, m_cfg[7]);
    endtask

    // Sample in the high phase and in the low phase of every cycle.
    always begin
        @(posedge clk);
        #6;
        if (chk_on && !done) compare(0);
        #10;
        if (chk_on && !done) compare(1);
    end

    task automatic cyc(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(logic [7:0] v);
        wr_data = v; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        // R1: reset state while reset is held
        cur_req = "R1";
        chk("ref_o reset", ref_w, 1'b0);
        chk("pin_oe_o reset", pin_oe_w, 1'b0);
        chk("slew_o reset", slew_w, 1'b1);
        rst_n = 1'b1;
        chk_on = 1'b1;
        cyc(4);

        // R2: other fields set but run bit clear
        cur_req = "R2";
        wr(8'hCA);
        cyc(20);

        // R3: every ratio code with 50% duty, pin driven
        cur_req = "R3";
        for (int k = 0; k < 8; k++) begin
            wr(8'hC3 | 8'(k << 2));
            cyc(2 * (1 << k) + 6);
        end

        // R4: all duty codes at ratio 8, then 25% at ratio 128
        cur_req = "R4";
        for (int d = 0; d < 4; d++) begin
            wr(8'h83 | 8'(d << 5) | 8'(3 << 2));
            cyc(30);
        end
        wr(8'hA3 | 8'(7 << 2));
        cyc(300);

        // R5: ratio 1 with every duty code
        cur_req = "R5";
        for (int d = 0; d < 4; d++) begin
            wr(8'h83 | 8'(d << 5));
            cyc(10);
        end

        // R6: ratio 2 with every duty code
        cur_req = "R6";
        for (int d = 0; d < 4; d++) begin
            wr(8'h83 | 8'(d << 5) | 8'(1 << 2));
            cyc(12);
        end

        // R7: change settings mid-period; old period must complete
        cur_req = "R7";
        wr(8'hA3 | 8'(4 << 2));
        cyc(21);
        wr(8'hE3 | 8'(2 << 2));
        cyc(40);
        wr(8'hC3 | 8'(3 << 2));
        cyc(3);
        wr(8'h83 | 8'(1 << 2));
        cyc(20);

        // R8: run without pin-drive, then pin-drive without run
        cur_req = "R8";
        wr(8'hC1 | 8'(2 << 2));
        cyc(16);
        wr(8'hC2 | 8'(2 << 2));
        cyc(16);
        wr(8'hC3 | 8'(2 << 2));
        cyc(8);

        // R9: oscillator mode takes the pin, reference keeps running
        cur_req = "R9";
        xtal = 1'b1;
        cyc(20);
        clkout = 1'b1;
        cyc(10);
        xtal = 1'b0;

        // R10: quarter-rate clock owns the pin
        cur_req = "R10";
        cyc(20);
        clkout = 1'b0;
        cyc(4);

        // R11: sleep mid-period with a write attempt, then resume
        cur_req = "R11";
        wr(8'hE3 | 8'(5 << 2));
        cyc(13);
        sleep = 1'b1;
        cyc(5);
        wr(8'h40);
        cyc(10);
        sleep = 1'b0;
        cyc(70);
        wr(8'hC3);
        cyc(3);
        sleep = 1'b1;
        cyc(6);
        sleep = 1'b0;
        cyc(6);

        // R12: slew-limit bit follows the configuration word
        cur_req = "R12";
        wr(8'h43);
        cyc(5);
        wr(8'hC3);
        cyc(5);

        finish_run();
    end

endmodule